// File: doc/BRIEF.md
# ADC Single-Pass Scan Sequencer

This block is the digital control side of an analog-to-digital converter that walks once over a group of selected input channels and then stops. Four start inputs can launch a pass: a software set of the run bit, two timer event pulses and an external event pulse. Any one of them is enough. A fixed settling delay follows the launch. The sequencer then visits the enabled channels in rising index order, one conversion each.

For each channel the sequencer opens a sample window on the converter interface and pulses a start strobe in the window's last cycle. It then waits for the converter's done strobe and stores the returned 10-bit code in that channel's result slot. The first window of a pass is set by its own length input, and the later windows by a second, usually shorter, length. When the last channel is stored, the run status drops and a sticky completion flag is set. That flag can drive an interrupt. Software can abort a pass by clearing the run bit. The flag is then left clear, and the conversion in flight is discarded.

The sample-and-hold and the successive-approximation core are outside the block. They are seen only through the select, window, start, done and result signals.

Top module: `adc_scan_seq`

## Requirements
- R1: A one-cycle pulse on any of `sw_start_set`, `trig_tmr_a`, `trig_tmr_b` or `trig_ext` while idle, with `ch_mask` non-zero and `sw_start_clr` low, sets `scan_busy` on the next clock edge. With `ch_mask` all zero, a start request leaves `scan_busy` and `end_flag` low.
- R2: After the edge that sets `scan_busy`, exactly START_DLY cycles pass with `conv_sample` low before the first sample window opens.
- R3: Each channel whose `ch_mask` bit is 1 is converted exactly once per pass, in ascending index order, and `conv_ch` names it during its window.
- R4: The first window of a pass keeps `conv_sample` high for `first_len` cycles and every later window for `next_len` cycles, with a length of 0 treated as 1. `conv_start` is high only in the last cycle of each window.
- R5: A `conv_done` pulse during the conversion phase stores `conv_result` into bits `c*RES_W +: RES_W` of `result_bus`, where c is the channel being converted. All other slots keep their values. A `conv_done` pulse while idle has no effect.
- R6: On the edge that stores the last selected channel, `scan_busy` falls and `end_flag` rises.
- R7: `irq` is high exactly when `end_flag` and `irq_en` are both high.
- R8: `end_flag` stays set until a `flag_clr` pulse clears it.
- R9: `sw_start_clr` high while `scan_busy` is high returns the block to idle on the next edge. In that case `end_flag` is not set and no result slot changes, including the one whose conversion was in flight.
- R10: Start requests that arrive while a pass is running are ignored, and no second pass follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_start_set | input | 1 | Software write of 1 to the run bit |
| sw_start_clr | input | 1 | Software write of 0 to the run bit (abort) |
| trig_tmr_a | input | 1 | First timer start event |
| trig_tmr_b | input | 1 | Second timer start event |
| trig_ext | input | 1 | External start event |
| ch_mask | input | NCH | Channel group, bit c selects channel c |
| first_len | input | CNT_W | Sample window length of the first conversion |
| next_len | input | CNT_W | Sample window length of later conversions |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Write-one-to-clear of the completion flag |
| scan_busy | output | 1 | Run bit, high while a pass is active |
| conv_ch | output | CH_W | Channel select to the converter |
| conv_sample | output | 1 | Sample window to the sample-and-hold |
| conv_start | output | 1 | Conversion start strobe |
| conv_done | input | 1 | Conversion complete strobe |
| conv_result | input | RES_W | Converted code |
| result_bus | output | NCH*RES_W | All channel result slots |
| end_flag | output | 1 | Sticky completion flag |
| irq | output | 1 | Interrupt request |

## Verification
The bound checker tests several properties on every cycle. Each start strobe carries a higher channel than the one before it in the same pass. Every window closes right after its strobe. The result slots never move while idle or on an abort edge. A finished pass always raises the flag and drops the run status, and the flag only rises from such a finish. The remaining behaviour can only be shown by the bench's scenarios. This covers the exact delay and window lengths, the values written to each slot under every channel group, the interrupt gating, the flag's hold-and-clear, the zero-length rule, and the rejection of start requests during a pass.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  // Number of start sources merged into one request
  localparam int NUM_START_SRC = 4;

  // Phase of the pass
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DELAY  = 2'd1,
    ST_SAMPLE = 2'd2,
    ST_CONV   = 2'd3
  } scan_state_e;

endpackage

// File: rtl/adc_trig_merge.sv
module adc_trig_merge #(
  parameter int NSRC = 4
) (
  input  logic [NSRC-1:0] src,
  output logic            req
);
  // Any source pulse asks for a pass
  assign req = |src;
endmodule

// File: rtl/adc_chan_pick.sv
module adc_chan_pick #(
  parameter int NCH  = 8,
  parameter int CH_W = 3
) (
  input  logic [NCH-1:0]  mask,
  input  logic [CH_W-1:0] from_ch,
  input  logic            incl,
  output logic            found,
  output logic [CH_W-1:0] pick
);
  logic [NCH-1:0] cand;

  // Candidate channels: above from_ch, or equal to it when incl is set
  for (genvar i = 0; i < NCH; i++) begin : g_cand
    assign cand[i] = mask[i] &&
                     ((CH_W'(i) > from_ch) || (incl && (CH_W'(i) == from_ch)));
  end

  // Lowest candidate wins
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found = 1'b1;
        pick  = CH_W'(i);
      end
    end
  end
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int NCH   = 8,
  parameter int RES_W = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCH-1:0]       wr_en,
  input  logic [RES_W-1:0]     wr_data,
  output logic [NCH*RES_W-1:0] bank
);
  for (genvar i = 0; i < NCH; i++) begin : g_slot
    logic [RES_W-1:0] slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        slot_q <= '0;
      else if (wr_en[i]) slot_q <= wr_data;
    end
    assign bank[i*RES_W +: RES_W] = slot_q;
  end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int NCH       = 8,
  parameter int RES_W     = 10,
  parameter int CNT_W     = 6,
  parameter int START_DLY = 4,
  localparam int CH_W     = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sw_start_set,
  input  logic                 sw_start_clr,
  input  logic                 trig_tmr_a,
  input  logic                 trig_tmr_b,
  input  logic                 trig_ext,
  input  logic [NCH-1:0]       ch_mask,
  input  logic [CNT_W-1:0]     first_len,
  input  logic [CNT_W-1:0]     next_len,
  input  logic                 irq_en,
  input  logic                 flag_clr,
  output logic                 scan_busy,
  output logic [CH_W-1:0]      conv_ch,
  output logic                 conv_sample,
  output logic                 conv_start,
  input  logic                 conv_done,
  input  logic [RES_W-1:0]     conv_result,
  output logic [NCH*RES_W-1:0] result_bus,
  output logic                 end_flag,
  output logic                 irq
);

  localparam logic [CNT_W-1:0] DLY_INIT = CNT_W'(START_DLY - 1);

  // Last count value of a window of n cycles; n = 0 behaves as 1
  function automatic logic [CNT_W-1:0] win_last(input logic [CNT_W-1:0] n);
    return (n == '0) ? '0 : n - CNT_W'(1);
  endfunction

  scan_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CH_W-1:0]  ch_q;
  logic [NCH-1:0]   mask_q;
  logic             flag_q;

  // Named internal events
  logic             start_req;
  logic             first_found;
  logic [CH_W-1:0]  first_ch;
  logic             more_found;
  logic [CH_W-1:0]  next_ch;
  logic             cnt_zero;
  logic             scan_go;
  logic             abort_evt;
  logic             store_evt;
  logic             scan_done_evt;
  logic [NCH-1:0]   wr_en;

  adc_trig_merge #(.NSRC(NUM_START_SRC)) u_trig (
    .src ({sw_start_set, trig_tmr_a, trig_tmr_b, trig_ext}),
    .req (start_req)
  );

  adc_chan_pick #(.NCH(NCH), .CH_W(CH_W)) u_pick_first (
    .mask    (ch_mask),
    .from_ch ('0),
    .incl    (1'b1),
    .found   (first_found),
    .pick    (first_ch)
  );

  adc_chan_pick #(.NCH(NCH), .CH_W(CH_W)) u_pick_next (
    .mask    (mask_q),
    .from_ch (ch_q),
    .incl    (1'b0),
    .found   (more_found),
    .pick    (next_ch)
  );

  assign cnt_zero      = (cnt_q == '0);
  assign scan_go       = (state_q == ST_IDLE) && start_req && !sw_start_clr && first_found;
  assign abort_evt     = (state_q != ST_IDLE) && sw_start_clr;
  assign store_evt     = (state_q == ST_CONV) && conv_done && !sw_start_clr;
  assign scan_done_evt = store_evt && !more_found;

  for (genvar i = 0; i < NCH; i++) begin : g_wr
    assign wr_en[i] = store_evt && (ch_q == CH_W'(i));
  end

  adc_result_bank #(.NCH(NCH), .RES_W(RES_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (conv_result),
    .bank    (result_bus)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      ch_q    <= '0;
      mask_q  <= '0;
    end else if (abort_evt) begin
      state_q <= ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (scan_go) begin
            state_q <= ST_DELAY;
            cnt_q   <= DLY_INIT;
            mask_q  <= ch_mask;
            ch_q    <= first_ch;
          end
        end
        ST_DELAY: begin
          if (cnt_zero) begin
            state_q <= ST_SAMPLE;
            cnt_q   <= win_last(first_len);
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        ST_SAMPLE: begin
          if (cnt_zero) state_q <= ST_CONV;
          else          cnt_q   <= cnt_q - CNT_W'(1);
        end
        ST_CONV: begin
          if (conv_done) begin
            if (more_found) begin
              ch_q    <= next_ch;
              state_q <= ST_SAMPLE;
              cnt_q   <= win_last(next_len);
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Completion flag: set wins over the clear write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             flag_q <= 1'b0;
    else if (scan_done_evt) flag_q <= 1'b1;
    else if (flag_clr)      flag_q <= 1'b0;
  end

  assign scan_busy   = (state_q != ST_IDLE);
  assign conv_ch     = ch_q;
  assign conv_sample = (state_q == ST_SAMPLE);
  assign conv_start  = (state_q == ST_SAMPLE) && cnt_zero;
  assign end_flag    = flag_q;
  assign irq         = flag_q && irq_en;

endmodule

// File: rtl/adc_scan_chk.sv
module adc_scan_chk #(
  parameter int NCH   = 8,
  parameter int RES_W = 10,
  parameter int CH_W  = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 scan_busy,
  input logic                 conv_start,
  input logic                 conv_sample,
  input logic [CH_W-1:0]      conv_ch,
  input logic [NCH*RES_W-1:0] result_bus,
  input logic                 end_flag,
  input logic                 abort_evt,
  input logic                 scan_done_evt
);
  logic            have_last;
  logic [CH_W-1:0] last_ch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_last <= 1'b0;
      last_ch   <= '0;
    end else if (!scan_busy) begin
      have_last <= 1'b0;
    end else if (conv_start) begin
      have_last <= 1'b1;
      last_ch   <= conv_ch;
    end
  end

  // R3
  ascending_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start && have_last |-> conv_ch > last_ch);

  // R4
  window_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_sample);

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_busy |=> $stable(result_bus));

  // R6
  finish_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done_evt |=> end_flag && !scan_busy);

  // R8
  flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(end_flag) |-> $past(scan_done_evt));

  // R9
  abort_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> !scan_busy && $stable(result_bus) && !$rose(end_flag));
endmodule

bind adc_scan_seq adc_scan_chk #(
  .NCH   (NCH),
  .RES_W (RES_W),
  .CH_W  (CH_W)
) u_scan_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .scan_busy     (scan_busy),
  .conv_start    (conv_start),
  .conv_sample   (conv_sample),
  .conv_ch       (conv_ch),
  .result_bus    (result_bus),
  .end_flag      (end_flag),
  .abort_evt     (abort_evt),
  .scan_done_evt (scan_done_evt)
);

// File: tb/tb_adc_scan_seq.sv
module tb_adc_scan_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NCH        = 8;
  localparam int RES_W      = 10;
  localparam int CNT_W      = 6;
  localparam int START_DLY  = 4;
  localparam int CH_W       = 3;
  localparam int LAT        = 2;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 sw_start_set = 1'b0, sw_start_clr = 1'b0;
  logic                 trig_tmr_a = 1'b0, trig_tmr_b = 1'b0, trig_ext = 1'b0;
  logic [NCH-1:0]       ch_mask = '0;
  logic [CNT_W-1:0]     first_len = '0, next_len = '0;
  logic                 irq_en = 1'b0, flag_clr = 1'b0;
  logic                 scan_busy, conv_sample, conv_start, end_flag, irq;
  logic [CH_W-1:0]      conv_ch;
  logic                 conv_done = 1'b0;
  logic [RES_W-1:0]     conv_result = '0;
  logic [NCH*RES_W-1:0] result_bus;

  adc_scan_seq #(.NCH(NCH), .RES_W(RES_W), .CNT_W(CNT_W), .START_DLY(START_DLY)) dut (
    .clk(clk), .rst_n(rst_n), .sw_start_set(sw_start_set), .sw_start_clr(sw_start_clr),
    .trig_tmr_a(trig_tmr_a), .trig_tmr_b(trig_tmr_b), .trig_ext(trig_ext),
    .ch_mask(ch_mask), .first_len(first_len), .next_len(next_len),
    .irq_en(irq_en), .flag_clr(flag_clr), .scan_busy(scan_busy), .conv_ch(conv_ch),
    .conv_sample(conv_sample), .conv_start(conv_start), .conv_done(conv_done),
    .conv_result(conv_result), .result_bus(result_bus), .end_flag(end_flag), .irq(irq)
  );

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0;
  int fails   = 0;
  int pass_id = 0;
  int exp_bank [NCH];

  function automatic int exp_res(input int ch, input int pass);
    return (ch * 37 + pass * 11 + 5) % 1024;
  endfunction

  function automatic int eff_len(input int n);
    return (n == 0) ? 1 : n;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Converter model and pass monitor
  int seq_ch [16];
  int samp_len [16];
  int seq_n = 0, dly_n = 0, samp_cnt = 0, pend = 0, pend_ch = 0;
  bit seen_samp = 0, prev_busy = 0;

  always @(negedge clk) begin
    conv_done = 1'b0;
    if (!rst_n) begin
      prev_busy = 0;
      pend      = 0;
    end else begin
      if (scan_busy && !prev_busy) begin
        seq_n = 0; dly_n = 0; samp_cnt = 0; seen_samp = 0;
      end
      prev_busy = scan_busy;
      if (scan_busy && !conv_sample && !seen_samp) dly_n++;
      if (conv_sample) begin
        seen_samp = 1;
        samp_cnt++;
      end
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          conv_done   = 1'b1;
          conv_result = RES_W'(exp_res(pend_ch, pass_id));
        end
      end
      if (conv_start) begin
        if (seq_n < 16) begin
          seq_ch[seq_n]   = int'(conv_ch);
          samp_len[seq_n] = samp_cnt;
        end
        seq_n++;
        samp_cnt = 0;
        pend     = LAT;
        pend_ch  = int'(conv_ch);
      end
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic check_bank(input string req);
    for (int c = 0; c < NCH; c++)
      chk(int'(result_bus[c*RES_W +: RES_W]) == exp_bank[c], req,
          int'(result_bus[c*RES_W +: RES_W]), exp_bank[c]);
  endtask

  task automatic pulse_src(input int src, input logic v);
    case (src)
      0:       sw_start_set = v;
      1:       trig_tmr_a   = v;
      2:       trig_tmr_b   = v;
      default: trig_ext     = v;
    endcase
  endtask

  task automatic run_scan(input logic [NCH-1:0] m, input int src,
                          input int f, input int n, input bit ie);
    int k;
    pass_id++;
    ch_mask   = m;
    first_len = CNT_W'(f);
    next_len  = CNT_W'(n);
    irq_en    = ie;
    pulse_src(src, 1'b1);
    step();
    pulse_src(src, 1'b0);
    chk(scan_busy == 1'b1, "R1 busy after start", int'(scan_busy), 1);
    while (scan_busy) step();
    chk(dly_n == START_DLY, "R2 start delay", dly_n, START_DLY);
    chk(seq_n == $countones(m), "R3 conversion count", seq_n, $countones(m));
    k = 0;
    for (int c = 0; c < NCH; c++) begin
      if (m[c]) begin
        if (k < 16) begin
          chk(seq_ch[k] == c, "R3 channel order", seq_ch[k], c);
          chk(samp_len[k] == ((k == 0) ? eff_len(f) : eff_len(n)), "R4 window length",
              samp_len[k], (k == 0) ? eff_len(f) : eff_len(n));
        end
        exp_bank[c] = exp_res(c, pass_id);
        k++;
      end
    end
    check_bank("R5 result slots");
    chk(end_flag == 1'b1, "R6 end flag at finish", int'(end_flag), 1);
    chk(irq == ie, "R7 irq gating", int'(irq), int'(ie));
    step();
    chk(end_flag == 1'b1, "R8 flag holds", int'(end_flag), 1);
    flag_clr = 1'b1;
    step();
    flag_clr = 1'b0;
    chk(end_flag == 1'b0, "R8 flag cleared", int'(end_flag), 0);
    chk(irq == 1'b0, "R7 irq after clear", int'(irq), 0);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) exp_bank[c] = 0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // Reset state
    chk(scan_busy == 1'b0, "R1 reset busy", int'(scan_busy), 0);
    chk(end_flag == 1'b0, "R6 reset flag", int'(end_flag), 0);
    chk(irq == 1'b0, "R7 reset irq", int'(irq), 0);
    chk(conv_sample == 1'b0, "R4 reset window", int'(conv_sample), 0);
    check_bank("R5 reset slots");

    // R1: empty group does not start
    ch_mask = '0;
    sw_start_set = 1'b1;
    step();
    sw_start_set = 1'b0;
    chk(scan_busy == 1'b0, "R1 empty group", int'(scan_busy), 0);
    step();
    chk(end_flag == 1'b0, "R1 empty group flag", int'(end_flag), 0);

    // Sweep of every non-empty channel group and every start source
    for (int m = 1; m < 256; m++)
      run_scan(NCH'(m), m % 4, 3 + (m % 3), 1 + (m % 2), ((m / 3) % 2) == 1);

    // R4: zero lengths behave as one cycle
    run_scan(8'b1010_0001, 2, 0, 0, 1'b1);

    // R10: start requests during a pass are ignored
    pass_id++;
    ch_mask = 8'h0F; first_len = 6'd4; next_len = 6'd2; irq_en = 1'b0;
    trig_tmr_a = 1'b1;
    step();
    trig_tmr_a = 1'b0;
    repeat (6) step();
    sw_start_set = 1'b1; trig_ext = 1'b1; trig_tmr_b = 1'b1;
    step();
    sw_start_set = 1'b0; trig_ext = 1'b0; trig_tmr_b = 1'b0;
    while (scan_busy) step();
    for (int c = 0; c < 4; c++) exp_bank[c] = exp_res(c, pass_id);
    chk(seq_n == 4, "R10 single pass", seq_n, 4);
    for (int i = 0; i < 8; i++) begin
      step();
      chk(scan_busy == 1'b0, "R10 no restart", int'(scan_busy), 0);
    end
    check_bank("R10 slots");
    flag_clr = 1'b1;
    step();
    flag_clr = 1'b0;

    // R9: abort while channel 2 is converting
    pass_id++;
    ch_mask = 8'hFF; first_len = 6'd3; next_len = 6'd2; irq_en = 1'b1;
    sw_start_set = 1'b1;
    step();
    sw_start_set = 1'b0;
    while (!(conv_start && conv_ch == 3'd2)) step();
    exp_bank[0] = exp_res(0, pass_id);
    exp_bank[1] = exp_res(1, pass_id);
    sw_start_clr = 1'b1;
    step();
    sw_start_clr = 1'b0;
    chk(scan_busy == 1'b0, "R9 abort idle", int'(scan_busy), 0);
    chk(end_flag == 1'b0, "R9 abort no flag", int'(end_flag), 0);
    chk(irq == 1'b0, "R9 abort no irq", int'(irq), 0);
    // stray done strobe arrives while idle (R5)
    repeat (5) step();
    check_bank("R9 in-flight result dropped");
    chk(scan_busy == 1'b0, "R5 stray done ignored", int'(scan_busy), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule